// File: doc/BRIEF.md
# Framebuffer scanout address generator

This block walks a framebuffer in memory one display line at a time and turns it into burst read requests for a display pipeline. When a frame-start pulse arrives, it captures a base byte address, a line length in bytes, a line pitch in bytes, a line count stored minus one, a burst-size select and a limit on outstanding reads. It then breaks each line into bursts of the selected size. If the line is not a whole number of bursts, the last burst of the line is shorter. After the last burst of a line, the next line starts one pitch further on. Once the request for the last burst of the last line has been accepted, the block raises a done flag and waits for the next frame start.

Requests leave through a simple valid/ready port. Each request carries a byte address and a beat count from 1 to 16, where one beat is `BEAT_BYTES` bytes. The memory side returns one completion pulse per finished request. The block counts accepted requests against completions and holds off new requests while the number of reads in flight equals the programmed limit. Data buffering and the full bus protocol belong to other blocks.

Top module: `fb_scan_addr_gen`

## Requirements
- R1: After reset, `reqValid` and `frameDone` are 0, and no request is presented until a frame-start pulse arrives.
- R2: Base, length, pitch, line count, burst select and outstanding limit are sampled only in the cycle `frameStart` is high. Changing these inputs during a frame has no effect on the frame in progress. The first request of a frame is presented in the cycle after the pulse, at the sampled base address.
- R3: The burst select maps 0 to 1 beat, 1 to 2 beats, 2 to 4 beats, 3 to 8 beats, and 4 through 7 to 16 beats.
- R4: Each line is fetched as ceil(length/BEAT_BYTES) beats, split into bursts of the selected size, with a shorter final burst when needed. Within a line, each burst address is the previous address plus its beat count times BEAT_BYTES.
- R5: Each frame fetches line-count-plus-one lines. The first request of each line is at the previous line's start address plus the pitch.
- R6: No request is presented while the number of accepted requests minus returned completions equals the limit. A limit of 0 acts as 1. The count rises on each accepted request and falls on each completion.
- R7: While `reqValid` is high and `reqReady` is low, the request stays valid with the same address and beat count in the next cycle, unless a frame start intervenes.
- R8: `frameDone` goes to 1 in the cycle after the last request of the frame is accepted. After that, `reqValid` stays 0. `frameDone` returns to 0 on the next frame-start pulse.
- R9: A frame-start pulse during a frame drops the rest of that frame. The next request is the first request of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStart | input | 1 | One-cycle pulse that starts a frame and samples the configuration |
| cfgBase | input | ADDR_W | Byte address of the first pixel of the frame |
| cfgLineLen | input | LEN_W | Bytes fetched per line |
| cfgPitch | input | LEN_W | Byte step from one line start to the next |
| cfgLineCntM1 | input | CNT_W | Number of lines minus one |
| cfgBurstSel | input | 3 | Burst size select (see R3) |
| cfgMaxOut | input | OUT_W | Limit on requests in flight (0 acts as 1) |
| reqValid | output | 1 | Request presented |
| reqReady | input | 1 | Request accepted when high together with reqValid |
| reqAddr | output | ADDR_W | Byte address of the burst |
| reqBeats | output | 5 | Beats in the burst, 1 to 16 |
| cplValid | input | 1 | One request finished |
| frameDone | output | 1 | Last request of the frame accepted |

## Verification
The bench runs frames in four request patterns:
- Lines that are whole multiples of the burst separate address stepping from pitch stepping.
- Lines with a remainder show whether the short final burst has the right length and address.
- A sweep over all eight burst-select codes checks the beat decode.
- Ready held high versus ready toggling every cycle shows whether a stalled request is held steady.

Slow completions with small limits, including a limit of 0, show whether the in-flight count gates requests at exactly the limit. Changing the inputs in mid-frame and restarting in mid-frame show that configuration is sampled only at frame start.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;

  // Strobes from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic loadFrame;
    logic stepBurst;
    logic stepLine;
  } scanStrb_t;

  localparam int BURST_W = 5;

  function automatic logic [BURST_W-1:0] decodeBurst(input logic [2:0] sel);
    case (sel)
      3'd0:    return 5'd1;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/fb_scan_datapath.sv
module fb_scan_datapath
  import fb_scan_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int CNT_W      = 12,
  parameter int OUT_W      = 4,
  parameter int BEAT_BYTES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  scanStrb_t          strb,
  input  logic [ADDR_W-1:0]  cfgBase,
  input  logic [LEN_W-1:0]   cfgLineLen,
  input  logic [LEN_W-1:0]   cfgPitch,
  input  logic [CNT_W-1:0]   cfgLineCntM1,
  input  logic [2:0]         cfgBurstSel,
  input  logic [OUT_W-1:0]   cfgMaxOut,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic [BURST_W-1:0] reqBeats,
  output logic               lastOfLine,
  output logic               lastLine,
  output logic [OUT_W-1:0]   maxOut
);

  localparam int SHIFT = $clog2(BEAT_BYTES);

  logic [ADDR_W-1:0]  lineAddr, burstAddr, nextLine, burstBytes;
  logic [LEN_W-1:0]   pitchQ, lineBeatsQ, remainQ, lineBeatsIn;
  logic [LEN_W:0]     lenRound;
  logic [CNT_W-1:0]   linesLeft;
  logic [BURST_W-1:0] burstQ;
  logic [OUT_W-1:0]   maxOutQ;

  // Beats per line, rounded up to whole beats.
  generate
    if (SHIFT == 0) begin : g_byteBeat
      assign lenRound    = {1'b0, cfgLineLen};
      assign lineBeatsIn = cfgLineLen;
    end else begin : g_wideBeat
      assign lenRound    = {1'b0, cfgLineLen} + (LEN_W+1)'(BEAT_BYTES - 1);
      assign lineBeatsIn = LEN_W'(lenRound >> SHIFT);
    end
  endgenerate

  assign reqBeats   = (remainQ < LEN_W'(burstQ)) ? remainQ[BURST_W-1:0] : burstQ;
  assign burstBytes = ADDR_W'(reqBeats) << SHIFT;
  assign nextLine   = lineAddr + ADDR_W'(pitchQ);
  assign lastOfLine = (remainQ == LEN_W'(reqBeats));
  assign lastLine   = (linesLeft == '0);
  assign reqAddr    = burstAddr;
  assign maxOut     = maxOutQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineAddr   <= '0;
      burstAddr  <= '0;
      pitchQ     <= '0;
      lineBeatsQ <= '0;
      remainQ    <= '0;
      linesLeft  <= '0;
      burstQ     <= 5'd1;
      maxOutQ    <= OUT_W'(1);
    end else if (strb.loadFrame) begin
      lineAddr   <= cfgBase;
      burstAddr  <= cfgBase;
      pitchQ     <= cfgPitch;
      lineBeatsQ <= lineBeatsIn;
      remainQ    <= lineBeatsIn;
      linesLeft  <= cfgLineCntM1;
      burstQ     <= decodeBurst(cfgBurstSel);
      maxOutQ    <= (cfgMaxOut == '0) ? OUT_W'(1) : cfgMaxOut;
    end else if (strb.stepLine) begin
      lineAddr   <= nextLine;
      burstAddr  <= nextLine;
      remainQ    <= lineBeatsQ;
      linesLeft  <= linesLeft - CNT_W'(1);
    end else if (strb.stepBurst) begin
      burstAddr  <= burstAddr + burstBytes;
      remainQ    <= remainQ - LEN_W'(reqBeats);
    end
  end

endmodule

// File: rtl/fb_scan_control.sv
module fb_scan_control
  import fb_scan_pkg::*;
#(
  parameter int OUT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             reqReady,
  input  logic             cplValid,
  input  logic             lastOfLine,
  input  logic             lastLine,
  input  logic [OUT_W-1:0] maxOut,
  output scanStrb_t        strb,
  output logic             reqValid,
  output logic             frameDone,
  output logic [OUT_W:0]   outCnt
);

  typedef enum logic {S_IDLE, S_ISSUE} scanState_t;

  scanState_t state;
  logic       accept, frameEnd;

  assign reqValid = (state == S_ISSUE) && (outCnt < {1'b0, maxOut});
  assign accept   = reqValid && reqReady;
  assign frameEnd = accept && lastOfLine && lastLine;

  always_comb begin
    strb           = '0;
    strb.loadFrame = frameStart;
    strb.stepLine  = !frameStart && accept && lastOfLine && !lastLine;
    strb.stepBurst = !frameStart && accept && !lastOfLine;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      frameDone <= 1'b0;
    end else if (frameStart) begin
      state     <= S_ISSUE;
      frameDone <= 1'b0;
    end else if (frameEnd) begin
      state     <= S_IDLE;
      frameDone <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outCnt <= '0;
    end else if (accept && !cplValid) begin
      outCnt <= outCnt + (OUT_W+1)'(1);
    end else if (!accept && cplValid && outCnt != '0) begin
      outCnt <= outCnt - (OUT_W+1)'(1);
    end
  end

endmodule

// File: rtl/fb_scan_addr_gen.sv
module fb_scan_addr_gen
  import fb_scan_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int CNT_W      = 12,
  parameter int OUT_W      = 4,
  parameter int BEAT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [LEN_W-1:0]  cfgLineLen,
  input  logic [LEN_W-1:0]  cfgPitch,
  input  logic [CNT_W-1:0]  cfgLineCntM1,
  input  logic [2:0]        cfgBurstSel,
  input  logic [OUT_W-1:0]  cfgMaxOut,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [4:0]        reqBeats,
  input  logic              cplValid,
  output logic              frameDone
);

  scanStrb_t        strb;
  logic             lastOfLine, lastLine;
  logic [OUT_W-1:0] maxOut;
  logic [OUT_W:0]   outCnt;

  fb_scan_control #(.OUT_W(OUT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .reqReady(reqReady),
    .cplValid(cplValid), .lastOfLine(lastOfLine), .lastLine(lastLine),
    .maxOut(maxOut), .strb(strb), .reqValid(reqValid),
    .frameDone(frameDone), .outCnt(outCnt)
  );

  fb_scan_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
    .OUT_W(OUT_W), .BEAT_BYTES(BEAT_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgBase(cfgBase),
    .cfgLineLen(cfgLineLen), .cfgPitch(cfgPitch), .cfgLineCntM1(cfgLineCntM1),
    .cfgBurstSel(cfgBurstSel), .cfgMaxOut(cfgMaxOut), .reqAddr(reqAddr),
    .reqBeats(reqBeats), .lastOfLine(lastOfLine), .lastLine(lastLine),
    .maxOut(maxOut)
  );

endmodule

// File: rtl/fb_scan_checker.sv
module fb_scan_checker #(
  parameter int ADDR_W = 32,
  parameter int OUT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameStart,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [4:0]        reqBeats,
  input logic              cplValid,
  input logic              frameDone,
  input logic [OUT_W:0]    outCnt,
  input logic [OUT_W-1:0]  maxOut
);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady && !frameStart) |=>
      (reqValid && $stable(reqAddr) && $stable(reqBeats)));

  p_beats_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqBeats >= 5'd1 && reqBeats <= 5'd16));

  p_count_up_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !cplValid) |=> (outCnt == $past(outCnt) + 1'b1));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !frameStart) |=> (outCnt <= {1'b0, maxOut}));

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !frameStart) |=> (frameDone && !reqValid));

  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameDone) |-> $past(reqValid && reqReady));

  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameDone);

endmodule

bind fb_scan_addr_gen fb_scan_checker #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .reqValid(reqValid),
  .reqReady(reqReady), .reqAddr(reqAddr), .reqBeats(reqBeats),
  .cplValid(cplValid), .frameDone(frameDone), .outCnt(outCnt), .maxOut(maxOut)
);

// File: tb/test_fb_scan_addr_gen.sv
`timescale 1ns/1ps
module test_fb_scan_addr_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic [31:0] cfgBase = '0;
  logic [15:0] cfgLineLen = '0, cfgPitch = '0;
  logic [11:0] cfgLineCntM1 = '0;
  logic [2:0]  cfgBurstSel = '0;
  logic [3:0]  cfgMaxOut = '0;
  logic        reqValid, reqReady = 1'b0, cplValid = 1'b0, frameDone;
  logic [31:0] reqAddr;
  logic [4:0]  reqBeats;

  int checks = 0, failures = 0;
  int cycCnt = 0, pending = 0, cplPeriod = 1;
  bit ended = 0;
  logic [31:0] expAddr [0:1023];
  int          expBeats[0:1023];
  int          nExp;

  always #4 clk = ~clk;

  fb_scan_addr_gen i_fb_scan_addr_gen (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .cfgBase(cfgBase),
    .cfgLineLen(cfgLineLen), .cfgPitch(cfgPitch), .cfgLineCntM1(cfgLineCntM1),
    .cfgBurstSel(cfgBurstSel), .cfgMaxOut(cfgMaxOut), .reqValid(reqValid),
    .reqReady(reqReady), .reqAddr(reqAddr), .reqBeats(reqBeats),
    .cplValid(cplValid), .frameDone(frameDone)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cycCnt++;
    if (pending > 0 && (cycCnt % cplPeriod) == 0) begin
      cplValid = 1'b1;
      pending--;
    end else begin
      cplValid = 1'b0;
    end
  endtask

  task automatic drain();
    cplPeriod = 1;
    reqReady  = 1'b0;
    for (int i = 0; i < 64 && pending > 0; i++) tick();
    tick();
  endtask

  function automatic int beatsOf(input int sel);
    return (sel >= 4) ? 16 : (1 << sel);
  endfunction

  task automatic buildExp(input logic [31:0] base, input int len, input int pitch,
                          input int cntM1, input int sel);
    nExp = 0;
    for (int ln = 0; ln <= cntM1; ln++) begin
      int rem = (len + 7) / 8;
      int off = 0;
      while (rem > 0) begin
        int b = (rem < beatsOf(sel)) ? rem : beatsOf(sel);
        expAddr[nExp]  = base + 32'(ln * pitch) + 32'(off * 8);
        expBeats[nExp] = b;
        nExp++;
        off += b;
        rem -= b;
      end
    end
  endtask

  // Runs one frame and checks every accepted request against the model.
  task automatic runFrame(input logic [31:0] base, input int len, input int pitch,
                          input int cntM1, input int sel, input int maxo,
                          input int readyMode, input int period, input bit scramble,
                          input string tag);
    int idx = 0, guard = 0, effMax, dutCnt;
    bit stalled = 0, sawFull = 0;
    logic [31:0] heldAddr;
    logic [4:0]  heldBeats;
    drain();
    cplPeriod = period;
    effMax = (maxo == 0) ? 1 : maxo;
    buildExp(base, len, pitch, cntM1, sel);
    cfgBase = base; cfgLineLen = 16'(len); cfgPitch = 16'(pitch);
    cfgLineCntM1 = 12'(cntM1); cfgBurstSel = 3'(sel); cfgMaxOut = 4'(maxo);
    frameStart = 1'b1;
    tick();
    frameStart = 1'b0;
    if (scramble) begin  // R2: mid-frame changes must not matter
      cfgBase = 32'hDEAD_0000; cfgLineLen = 16'd8; cfgPitch = 16'd4;
      cfgLineCntM1 = 12'd0; cfgBurstSel = 3'd0; cfgMaxOut = 4'd1;
    end
    while (idx < nExp && guard < 4000) begin
      bit rdy = (readyMode == 0) ? 1'b1 : cycCnt[0];
      dutCnt = pending + (cplValid ? 1 : 0);
      if (stalled)
        chk(reqValid && reqAddr == heldAddr && reqBeats == heldBeats, "R7",
            "stalled request changed", {reqValid, reqAddr}, {1'b1, heldAddr});
      if (dutCnt >= effMax) begin
        sawFull = 1;
        chk(!reqValid, "R6", "valid at outstanding limit", reqValid, 0);
      end
      reqReady = rdy;
      if (reqValid && rdy) begin
        chk(reqAddr == expAddr[idx] && int'(reqBeats) == expBeats[idx], tag,
            $sformatf("request %0d addr/beats", idx),
            {reqAddr, 3'b0, reqBeats}, {expAddr[idx], 3'b0, 5'(expBeats[idx])});
        pending++;
        idx++;
      end
      stalled   = reqValid && !rdy;
      heldAddr  = reqAddr;
      heldBeats = reqBeats;
      tick();
      guard++;
    end
    reqReady = 1'b0;
    chk(idx == nExp, tag, "request count", idx, nExp);
    chk(frameDone && !reqValid, "R8", "done after last accept",
        {frameDone, reqValid}, 2'b10);
    if (period > 2)
      chk(sawFull, "R6", "limit reached", sawFull, 1);
    tick(); tick(); tick();
    chk(frameDone && !reqValid, "R8", "idle after done", {frameDone, reqValid}, 2'b10);
  endtask

  task automatic testReset();
    for (int i = 0; i < 4; i++) tick();
    rstN = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(!reqValid && !frameDone, "R1", "idle after reset", {reqValid, frameDone}, 0);
    end
  endtask

  task automatic testBasic();  // R2 R4 R5: whole bursts, mid-frame input changes
    runFrame(32'h0000_1000, 256, 512, 2, 4, 4, 0, 1, 1'b1, "R4 R5");
    chk(frameDone, "R2", "frame completed with sampled config", frameDone, 1);
  endtask

  task automatic testShortTail();  // R4: shorter final burst
    runFrame(32'h2000_0010, 200, 768, 1, 3, 3, 1, 2, 1'b0, "R4");
    runFrame(32'h0000_3000, 20, 64, 2, 2, 5, 0, 1, 1'b0, "R4");
  endtask

  task automatic testEncodings();  // R3: every burst select code
    for (int s = 0; s < 8; s++)
      runFrame(32'h4000 + 32'(s * 256), 64, 128, 0, s, 8, 0, 1, 1'b0, "R3");
  endtask

  task automatic testBackpressure();  // R7: ready toggling
    runFrame(32'h0001_0000, 384, 1024, 1, 4, 6, 1, 1, 1'b0, "R7");
  endtask

  task automatic testLimit();  // R6: slow completions, limit 2 and limit 0
    runFrame(32'h0002_0000, 512, 512, 0, 0, 2, 0, 5, 1'b0, "R6");
    runFrame(32'h0003_0000, 64, 64, 1, 1, 0, 0, 3, 1'b0, "R6");
  endtask

  task automatic testRestart();  // R9: frame start in mid-frame
    int got = 0;
    drain();
    cfgBase = 32'h0005_0000; cfgLineLen = 16'd1024; cfgPitch = 16'd2048;
    cfgLineCntM1 = 12'd3; cfgBurstSel = 3'd4; cfgMaxOut = 4'd15;
    frameStart = 1'b1;
    tick();
    frameStart = 1'b0;
    for (int i = 0; i < 20 && got < 3; i++) begin
      reqReady = 1'b1;
      if (reqValid) begin pending++; got++; end
      tick();
    end
    reqReady = 1'b0;
    cfgBase = 32'h0000_9000; cfgBurstSel = 3'd4;
    frameStart = 1'b1;
    tick();
    frameStart = 1'b0;
    chk(reqValid && reqAddr == 32'h9000 && reqBeats == 5'd16, "R9",
        "first request after restart", {reqValid, reqAddr, reqBeats},
        {1'b1, 32'h9000, 5'd16});
    chk(!frameDone, "R9", "done low after restart", frameDone, 0);
    runFrame(32'h0000_9000, 256, 256, 1, 4, 4, 0, 1, 1'b0, "R9");
  endtask

  initial begin
    testReset();
    testBasic();
    testShortTail();
    testEncodings();
    testBackpressure();
    testLimit();
    testRestart();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!ended) begin
      ended = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule